// File: doc/BRIEF.md
# Vector Find-Any-Equal Unit

This unit takes two 128-bit operands. The first is a search vector and the second is a set vector. It scans the search vector for the first element that equals any element of the set vector. The element width is chosen per request: 8, 16 or 32 bits. Every search lane is compared against every set lane in the same cycle. A priority encoder then keeps the leftmost hit, and the unit reports where that hit sits as a byte offset.

A request is presented with `in_valid`. One clock later the unit shows a registered 128-bit result with `out_valid` high, together with a `found` flag. The offset sits at the low end of the leftmost 64-bit half of the result. Every other bit of the result is zero. Between requests the result register holds its last value.

Top module: `vfind_any_eq`

## Requirements
- R1: Byte lane 0 is the most significant byte of each operand (bits 127:120). Element lane k of width W bytes occupies bits [127-8Wk -: 8W]. `elem_size` encodes 0 as byte, 1 as halfword, 2 as fullword, and 3 also as fullword.
- R2: A search element counts as a hit when it equals any element of the set vector, whatever set lane that element is in.
- R3: When several search elements hit, the reported position is the lowest-numbered hitting search lane. The order of values inside the set vector has no effect.
- R4: The reported offset equals the search lane index times the element width in bytes. For example, halfword lane 1 gives 2 and fullword lane 2 gives 8. Bytes that straddle element boundaries never form a hit.
- R5: The offset is placed in result bits 68:64. Result bits 127:69 and 63:0 are always zero.
- R6: When no search element hits, the offset field is 16 and `found` is 0. When there is a hit, `found` is 1 and the offset is below 16.
- R7: Every set lane takes part in the comparison, including zero lanes, so a zero search element matches zero padding in the set vector.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the result in that cycle belongs to that request.
- R9: While `in_valid` is low, `result` and `found` keep their values even if the operands change.
- R10: While `rst_n` is low, and directly after it is released, `out_valid`, `found` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| srch_vec | input | 128 | Search operand |
| set_vec | input | 128 | Set of values to look for |
| elem_size | input | 2 | Element width select (0 byte, 1 half, 2/3 word) |
| out_valid | output | 1 | Result valid, one cycle after request |
| found | output | 1 | At least one search element hit |
| result | output | 128 | Offset in bits 68:64, all else zero |

## Verification
The bench targets cases where lane order and element width interact:
- Set values listed in the reverse of their search order. A design that scans the set vector instead of the search vector returns the later position.
- A byte pair that matches only across a halfword boundary. A design that ignores lane alignment reports a false hit.
- Zero padding in the set vector against a zero search byte. A design that skips zero set lanes misses this hit.
- A hit in the last lane, a miss, and the reserved size code. These catch an off-by-one priority encoder, a wrong miss code of 0 or 15, and a reserved code decoded as byte.
- Idle cycles with changing operands. A design that forgets to gate the result register on `in_valid` overwrites the held result.

// File: rtl/vfind_pkg.sv
package vfind_pkg;

  localparam int FAE_DATA_W = 128;
  localparam int FAE_BYTE_W = 8;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_WALT = 2'd3
  } esize_e;

  // Index into the per-size hit table: 0 byte, 1 half, 2 word.
  function automatic logic [1:0] size_slot(input logic [1:0] code);
    case (code)
      2'd0:    size_slot = 2'd0;
      2'd1:    size_slot = 2'd1;
      default: size_slot = 2'd2;
    endcase
  endfunction

  // Bytes per element for a given slot.
  function automatic int slot_bytes(input int slot);
    slot_bytes = 1 << slot;
  endfunction

endpackage

// File: rtl/vfind_lane_cmp.sv
// All-pairs equality for one element width: hit[k] is set when search
// element k equals any set element.
module vfind_lane_cmp #(
  parameter int DATA_W = 128,
  parameter int ELEM_W = 8,
  localparam int LANES = DATA_W / ELEM_W
) (
  input  logic [DATA_W-1:0] srch,
  input  logic [DATA_W-1:0] setv,
  output logic [LANES-1:0]  hit
);

  logic [LANES-1:0][LANES-1:0] pair_eq;

  for (genvar k = 0; k < LANES; k++) begin : g_srch
    for (genvar m = 0; m < LANES; m++) begin : g_set
      assign pair_eq[k][m] =
        (srch[DATA_W-1-k*ELEM_W -: ELEM_W] == setv[DATA_W-1-m*ELEM_W -: ELEM_W]);
    end
    assign hit[k] = |pair_eq[k];
  end

endmodule

// File: rtl/vfind_first_pick.sv
// Priority encoder: lowest-numbered set bit wins; NPOS when none.
module vfind_first_pick #(
  parameter int NPOS = 16,
  localparam int OFF_W = $clog2(NPOS) + 1
) (
  input  logic [NPOS-1:0]  hit,
  output logic [OFF_W-1:0] pos,
  output logic             any
);

  always_comb begin
    pos = OFF_W'(NPOS);
    for (int b = NPOS - 1; b >= 0; b--) begin
      if (hit[b]) pos = OFF_W'(b);
    end
  end

  assign any = |hit;

endmodule

// File: rtl/vfind_result_fmt.sv
// Places the offset right-justified in the leftmost half of the result.
module vfind_result_fmt #(
  parameter int DATA_W = 128,
  parameter int OFF_W  = 5
) (
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] res
);

  localparam int HALF = DATA_W / 2;

  always_comb begin
    res = '0;
    res[HALF +: OFF_W] = off;
  end

endmodule

// File: rtl/vfind_any_eq.sv
module vfind_any_eq #(
  parameter int DATA_W = vfind_pkg::FAE_DATA_W,
  parameter int BYTE_W = vfind_pkg::FAE_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] srch_vec,
  input  logic [DATA_W-1:0] set_vec,
  input  logic [1:0]        elem_size,
  output logic              out_valid,
  output logic              found,
  output logic [DATA_W-1:0] result
);
  import vfind_pkg::*;

  localparam int NBYTES    = DATA_W / BYTE_W;
  localparam int OFF_W     = $clog2(NBYTES) + 1;
  localparam int NUM_SIZES = 3;

  // Byte-position hit map for every supported width.
  logic [NUM_SIZES-1:0][NBYTES-1:0] spread;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int EB    = 1 << g;
    localparam int LANES = NBYTES / EB;
    logic [LANES-1:0] lane_hit;

    vfind_lane_cmp #(
      .DATA_W (DATA_W),
      .ELEM_W (EB * BYTE_W)
    ) u_cmp (
      .srch (srch_vec),
      .setv (set_vec),
      .hit  (lane_hit)
    );

    for (genvar b = 0; b < NBYTES; b++) begin : g_pos
      if (b % EB == 0) begin : g_lead
        assign spread[g][b] = lane_hit[b / EB];
      end else begin : g_tail
        assign spread[g][b] = 1'b0;
      end
    end
  end

  // Named internal events, also observed by the checker.
  logic [1:0]        slot_w;
  logic [NBYTES-1:0] byte_hit_w;
  logic [OFF_W-1:0]  first_off_w;
  logic              any_hit_w;
  logic [DATA_W-1:0] fmt_w;

  assign slot_w     = size_slot(elem_size);
  assign byte_hit_w = spread[slot_w];

  vfind_first_pick #(.NPOS(NBYTES)) u_pick (
    .hit (byte_hit_w),
    .pos (first_off_w),
    .any (any_hit_w)
  );

  vfind_result_fmt #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_fmt (
    .off (first_off_w),
    .res (fmt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      found     <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        found  <= any_hit_w;
        result <= fmt_w;
      end
    end
  end

endmodule

// File: rtl/vfind_checker.sv
module vfind_checker #(
  parameter int DATA_W = 128,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        elem_size,
  input logic              any_hit_w,
  input logic              out_valid,
  input logic              found,
  input logic [DATA_W-1:0] result
);

  localparam int HALF  = DATA_W / 2;
  localparam int NPOS  = 1 << (OFF_W - 1);

  logic [OFF_W-1:0] off;
  assign off = result[HALF +: OFF_W];

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_valid_only_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_found_tracks_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (found == $past(any_hit_w)));

  assert_miss_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !found) |-> (off == OFF_W'(NPOS)));

  assert_hit_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && found) |-> (off < OFF_W'(NPOS)));

  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (result[HALF-1:0] == '0) && (result[DATA_W-1:HALF+OFF_W] == '0));

  assert_half_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_size == 2'd1) |=> (!found || off[0] == 1'b0));

  assert_word_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_size[1]) |=> (!found || off[1:0] == 2'b00));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(found)));

endmodule

bind vfind_any_eq vfind_checker #(.DATA_W(DATA_W), .OFF_W(OFF_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .elem_size (elem_size),
  .any_hit_w (any_hit_w),
  .out_valid (out_valid),
  .found     (found),
  .result    (result)
);

// File: tb/vfind_any_eq_tb.sv
`timescale 1ns/1ps
module vfind_any_eq_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inv = 1'b0;
  logic [127:0] srch = '0;
  logic [127:0] setv = '0;
  logic [1:0]   esz = 2'd0;
  logic         ov;
  logic         fnd;
  logic [127:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vfind_any_eq dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (inv),
    .srch_vec  (srch),
    .set_vec   (setv),
    .elem_size (esz),
    .out_valid (ov),
    .found     (fnd),
    .result    (res)
  );

  localparam int NV = 9;
  localparam logic [127:0] TV_S [NV] = '{
    128'h4142434445464748494A4B4C4D4E4F50,
    128'h4142434445464748494A4B4C4D4E4F50,
    128'h4142434445464748494A4B4C4D4E4F50,
    128'h4142434445464748494A4B4C4D4E4F50,
    128'h0102030405000708090A0B0C0D0E0F10,
    128'h0102030405060708090A0B0C0D0E0F10,
    128'h00123400010101010101010101010101,
    128'h00123400010101010101010101010101,
    128'h4142434445464748494A4B4C4D4E4F50
  };
  localparam logic [127:0] TV_T [NV] = '{
    128'h44430000000000000000000000000000,
    128'h44430000000000000000000000000000,
    128'h43440000000000000000000000000000,
    128'h000000000000000000000000494A4B4C,
    128'hFF000000000000000000000000000000,
    128'h10101010101010101010101010101010,
    128'h12341234123412341234123412341234,
    128'h12341234123412341234123412341234,
    128'h000000000000000000000000494A4B4C
  };
  localparam logic [1:0] TV_Z [NV] = '{2'd0, 2'd1, 2'd1, 2'd2, 2'd0, 2'd0, 2'd1, 2'd0, 2'd3};
  localparam int TV_OFF [NV] = '{2, 16, 2, 8, 5, 15, 16, 1, 8};
  localparam string TV_REQ [NV] = '{"R3", "R4", "R2", "R1", "R7", "R3", "R4", "R2", "R1"};

  // Reference: scan search lanes left to right, each against all set lanes.
  function automatic int ref_off(input logic [127:0] s, input logic [127:0] t,
                                 input logic [1:0] z);
    int eb = (z == 2'd0) ? 1 : (z == 2'd1) ? 2 : 4;
    int ew = eb * 8;
    logic [31:0] mask = (ew == 32) ? 32'hFFFF_FFFF : ((32'd1 << ew) - 32'd1);
    for (int i = 0; i < 16 / eb; i++) begin
      logic [31:0] a = 32'(s >> (128 - (i + 1) * ew)) & mask;
      for (int j = 0; j < 16 / eb; j++) begin
        logic [31:0] b = 32'(t >> (128 - (j + 1) * ew)) & mask;
        if (a == b) return i * eb;
      end
    end
    return 16;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [127:0] s, input logic [127:0] t, input logic [1:0] z);
    @(negedge clk);
    srch = s; setv = t; esz = z; inv = 1'b1;
    @(negedge clk);
    inv = 1'b0;
  endtask

  task automatic expect_out(input string req, input int off);
    check({req, "_valid"}, 128'(ov), 128'(1'b1));
    check({req, "_found"}, 128'(fnd), 128'(off != 16));
    check({req, "_result"}, res, 128'(off) << 64);
  endtask

  initial begin
    logic [127:0] held;
    // R10: reset state, even with a request pending
    inv = 1'b1;
    srch = 128'h1; setv = 128'h1;
    repeat (3) @(negedge clk);
    check("R10_valid", 128'(ov), 128'(0));
    check("R10_found", 128'(fnd), 128'(0));
    check("R10_result", res, 128'(0));
    inv = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10_after_release", {126'(0), ov, fnd} | res, 128'(0));

    for (int v = 0; v < NV; v++) begin
      run(TV_S[v], TV_T[v], TV_Z[v]);
      expect_out(TV_REQ[v], TV_OFF[v]);
    end

    // R8: no valid without a request
    @(negedge clk);
    check("R8_idle", 128'(ov), 128'(0));

    // R9: result holds while idle with changing operands
    run(TV_S[0], TV_T[0], 2'd0);
    held = res;
    srch = 128'h0; setv = 128'h0; esz = 2'd2;
    @(negedge clk);
    @(negedge clk);
    check("R9_hold", res, held);
    check("R9_found_hold", 128'(fnd), 128'(1));

    // R5/R6: random operands against the reference, all sizes
    for (int n = 0; n < 600; n++) begin
      logic [127:0] s, t;
      logic [1:0] z = 2'(n % 4);
      for (int w = 0; w < 4; w++) begin
        s[w*32 +: 32] = $urandom;
        t[w*32 +: 32] = $urandom;
      end
      if (n % 3 != 0) begin
        s = s & {16{8'h03}};
        t = t & {16{8'h03}};
      end
      if (n % 5 == 0) t = 128'(t[31:0]);
      run(s, t, z);
      expect_out("R5_R6_rand", ref_off(s, t, z));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule